// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the configuration header of a single-function PCI target. The transaction sequencer passes it the address phase of every bus cycle (command, select line and the low address byte) and then the completing data phase (write data and active-low byte enables). The block decides whether the cycle is a type-0 configuration access aimed at this device. If it is, the block claims the cycle and either presents the addressed register or updates the writable bits.

Identity fields (vendor, device, revision, class code, subsystem vendor and subsystem) and the status word are fixed by build parameters. The only writable state is the memory-space enable bit of the command word and the upper bits of a single 32 MB memory window register. Both are exported to the sequencer, which uses them to decode memory cycles.

Top module: `pci_cfg_header`

## Requirements
- R1: A cycle is claimed only when, at the address phase, the select input is high, the command is 4'b1010 (configuration read) or 4'b1011 (configuration write) and address bits 1:0 are 2'b00. Any other address phase leaves `cfg_claim` low, returns zero read data and changes no register.
- R2: Dword offset 0x00 reads {device ID, vendor ID}, with the device ID in bits 31:16. With the default parameters the value is 0x00014150.
- R3: After reset, offset 0x04 reads 0x02000002 (status 0x0200 in bits 31:16, command 0x0002 in bits 15:0), and `mem_enable` is 1.
- R4: Offset 0x10 is the window base register. Writing 0x3000_0000 with all byte lanes enabled reads back 0x3000_0000, and `bar0_base` then carries address bits 31:25 of that value.
- R5: The window is 32 MB, so bits 24:0 of the base register always read zero. This includes bits 3:0, which mark a 32-bit, non-prefetchable memory window. Writing 0xFFFF_FFFF reads back 0xFE00_0000.
- R6: Offset 0x08 reads {class code, revision ID} (0x05800001 by default). Offset 0x2C reads {subsystem ID, subsystem vendor ID} (0x00014150 by default).
- R7: Writes honour the byte enables, which are active low: bit n of `data_be_n` equal to 0 enables byte lane n (bits 8n+7:8n). A write with all enables high changes nothing. A write with only lane 3 enabled changes only base bits 31:25.
- R8: Command bit 1 (memory-space enable) is writable through lane 0 and drives `mem_enable`. All other command bits read as zero whatever is written.
- R9: Offsets that are not implemented (for example 0x0C, 0x3C, 0x40) read as zero, and writes to them are ignored.
- R10: Writes to read-only fields (identity, status, class, subsystem) have no effect.
- R11: `cfg_claim` rises in the cycle after a matching address phase and stays high, holding the read data, until the cycle after `data_valid`. `cfg_rdata` is zero whenever no configuration read is claimed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | Address phase present this cycle |
| addr_idsel | input | 1 | Configuration select line sampled at the address phase |
| addr_cmd | input | 4 | Bus command at the address phase |
| addr_ad | input | 8 | Low address byte (bits 7:2 dword offset, 1:0 access type) |
| data_valid | input | 1 | Data phase completes this cycle |
| data_wdata | input | 32 | Write data of the completing data phase |
| data_be_n | input | 4 | Active-low byte enables of the data phase |
| cfg_claim | output | 1 | A configuration cycle to this device is in progress |
| cfg_rdata | output | 32 | Register contents for a claimed read, zero otherwise |
| mem_enable | output | 1 | Memory-space enable, command bit 1 |
| bar0_base | output | 7 | Window base address bits 31:25 |

## Verification
The assertions assume that the sequencer gives at most one data phase per claimed configuration cycle, and that `data_valid` is never raised in the same cycle as `addr_valid`. The assertions on claim timing and on register updates rely on this ordering. The bench keeps to it: every access is one address-phase cycle followed by one data-phase cycle, and the two are driven on separate falling edges. A directed test also holds the claim open for idle cycles before the data phase.

// File: rtl/pci_cfg_pkg.sv
// Shared constants and types of the configuration header.
// Assumes dword offsets come from address bits 7:2 of the address phase.
package pci_cfg_pkg;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    localparam logic [5:0] IDX_IDENT   = 6'h00;  // offset 0x00
    localparam logic [5:0] IDX_CMDSTAT = 6'h01;  // offset 0x04
    localparam logic [5:0] IDX_CLASS   = 6'h02;  // offset 0x08
    localparam logic [5:0] IDX_WINDOW  = 6'h04;  // offset 0x10
    localparam logic [5:0] IDX_SUBSYS  = 6'h0B;  // offset 0x2C

    // Latched selection of the current configuration cycle
    typedef struct packed {
        logic       active;
        logic       write;
        logic [5:0] idx;
    } cfg_sel_t;
endpackage

// File: rtl/cfg_addr_decode.sv
// Address-phase decoder: claims type-0 configuration cycles aimed at this
// device and holds the selection until the data phase completes.
// Assumes one data phase per configuration cycle.
module cfg_addr_decode
    import pci_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_valid,
    input  logic       addr_idsel,
    input  logic [3:0] addr_cmd,
    input  logic [7:0] addr_ad,
    input  logic       data_valid,
    output cfg_sel_t   sel
);
    logic is_cfg_cmd;
    logic hit;

    // Recognise a type-0 configuration command addressed through the select line
    always_comb begin
        is_cfg_cmd = (addr_cmd == CMD_CFG_RD) || (addr_cmd == CMD_CFG_WR);
        hit        = addr_idsel && is_cfg_cmd && (addr_ad[1:0] == 2'b00);
    end

    // Latch the selection at the address phase, release it after the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (addr_valid) begin
            sel.active <= hit;
            sel.write  <= (addr_cmd == CMD_CFG_WR);
            sel.idx    <= addr_ad[7:2];
        end else if (data_valid) begin
            sel.active <= 1'b0;
        end
    end

    // R1
    claim_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel.active) |-> $past(addr_valid && addr_idsel && addr_ad[1:0] == 2'b00 &&
                                    (addr_cmd == CMD_CFG_RD || addr_cmd == CMD_CFG_WR)));

    // R11
    claim_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.active && data_valid && !addr_valid) |=> !sel.active);

    // R11
    claim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.active && !data_valid && !addr_valid) |=> (sel.active && $stable(sel.idx)));
endmodule

// File: rtl/cfg_wr_regs.sv
// Writable configuration state: command word and memory window base.
// Each register is updated through a per-bit mask built from the writable
// field and the active-low byte enables; bits outside the field stay zero.
module cfg_wr_regs
    import pci_cfg_pkg::*;
#(
    parameter int         WIN_SIZE_LOG2 = 25,
    parameter logic       MEM_EN_RESET  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_fire,
    input  logic [5:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_be_n,
    output logic [15:0] cmd_word,
    output logic [31:0] win_word
);
    localparam logic [15:0] CMD_WMASK   = 16'h0002;
    localparam logic [31:0] WIN_WMASK   = ~((32'h1 << WIN_SIZE_LOG2) - 32'h1);
    localparam logic [15:0] CMD_RST_VAL = {14'b0, MEM_EN_RESET, 1'b0};

    logic [31:0] lane_mask;
    logic [15:0] cmd_mask;
    logic [31:0] win_mask;

    // Expand the active-low byte enables into a bit mask
    for (genvar ln = 0; ln < 4; ln++) begin : g_lane
        assign lane_mask[ln*8 +: 8] = {8{~wr_be_n[ln]}};
    end

    // Combine the writable field, the lane mask and the register select
    always_comb begin
        cmd_mask = (wr_fire && wr_idx == IDX_CMDSTAT) ? (CMD_WMASK & lane_mask[15:0]) : '0;
        win_mask = (wr_fire && wr_idx == IDX_WINDOW)  ? (WIN_WMASK & lane_mask)       : '0;
    end

    // Update only the enabled writable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word <= CMD_RST_VAL;
            win_word <= '0;
        end else begin
            cmd_word <= (cmd_word & ~cmd_mask) | (wr_data[15:0] & cmd_mask);
            win_word <= (win_word & ~win_mask) | (wr_data & win_mask);
        end
    end

    // R8
    mem_en_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_word[1]) |-> $past(wr_fire && wr_idx == IDX_CMDSTAT && !wr_be_n[0]));

    // R7
    win_lane3_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_idx == IDX_WINDOW && wr_be_n[3]) |=> $stable(win_word[31:24]));

    // R4
    win_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_idx == IDX_WINDOW && wr_be_n == 4'b0000)
            |=> win_word[31:WIN_SIZE_LOG2] == $past(wr_data[31:WIN_SIZE_LOG2]));

    // R9
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_fire || (wr_idx != IDX_CMDSTAT && wr_idx != IDX_WINDOW))
            |=> ($stable(cmd_word) && $stable(win_word)));
endmodule

// File: rtl/cfg_rd_mux.sv
// Read multiplexer: assembles the addressed dword from build parameters and
// the writable registers. Zero for unimplemented offsets or when no read is active.
module cfg_rd_mux
    import pci_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h4150,
    parameter logic [15:0] DEVICE_ID     = 16'h0001,
    parameter logic [7:0]  REVISION_ID   = 8'h01,
    parameter logic [23:0] CLASS_CODE    = 24'h058000,
    parameter logic [15:0] SUB_VENDOR_ID = 16'h4150,
    parameter logic [15:0] SUB_ID        = 16'h0001,
    parameter logic [15:0] STATUS_VALUE  = 16'h0200
) (
    input  logic        rd_en,
    input  logic [5:0]  rd_idx,
    input  logic [15:0] cmd_word,
    input  logic [31:0] win_word,
    output logic [31:0] rd_data
);
    // Select the dword for the latched offset
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (rd_idx)
                IDX_IDENT:   rd_data = {DEVICE_ID, VENDOR_ID};
                IDX_CMDSTAT: rd_data = {STATUS_VALUE, cmd_word};
                IDX_CLASS:   rd_data = {CLASS_CODE, REVISION_ID};
                IDX_WINDOW:  rd_data = win_word;
                IDX_SUBSYS:  rd_data = {SUB_ID, SUB_VENDOR_ID};
                default:     rd_data = '0;
            endcase
        end
    end

    // R11
    always_comb begin
        idle_zero_chk: assert (rd_en || rd_data == 32'h0);
    end
endmodule

// File: rtl/pci_cfg_header.sv
// Type-0 configuration header of a single-function target.
// Claims configuration cycles, serves identity/command/status/window reads,
// applies byte-enabled writes and exports the window base and memory enable.
// Assumes the sequencer gives one data phase per cycle and never raises
// data_valid together with addr_valid.
module pci_cfg_header
    import pci_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h4150,
    parameter logic [15:0] DEVICE_ID     = 16'h0001,
    parameter logic [7:0]  REVISION_ID   = 8'h01,
    parameter logic [23:0] CLASS_CODE    = 24'h058000,
    parameter logic [15:0] SUB_VENDOR_ID = 16'h4150,
    parameter logic [15:0] SUB_ID        = 16'h0001,
    parameter logic [15:0] STATUS_VALUE  = 16'h0200,
    parameter logic        MEM_EN_RESET  = 1'b1,
    parameter int          WIN_SIZE_LOG2 = 25,
    localparam int         BASE_W        = 32 - WIN_SIZE_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic              addr_idsel,
    input  logic [3:0]        addr_cmd,
    input  logic [7:0]        addr_ad,
    input  logic              data_valid,
    input  logic [31:0]       data_wdata,
    input  logic [3:0]        data_be_n,
    output logic              cfg_claim,
    output logic [31:0]       cfg_rdata,
    output logic              mem_enable,
    output logic [BASE_W-1:0] bar0_base
);
    cfg_sel_t    sel;
    logic        wr_fire;
    logic        rd_en;
    logic [15:0] cmd_word;
    logic [31:0] win_word;

    cfg_addr_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_valid (addr_valid),
        .addr_idsel (addr_idsel),
        .addr_cmd   (addr_cmd),
        .addr_ad    (addr_ad),
        .data_valid (data_valid),
        .sel        (sel)
    );

    // Qualify the data phase for writes and the held selection for reads
    always_comb begin
        wr_fire = sel.active && sel.write && data_valid;
        rd_en   = sel.active && !sel.write;
    end

    cfg_wr_regs #(
        .WIN_SIZE_LOG2 (WIN_SIZE_LOG2),
        .MEM_EN_RESET  (MEM_EN_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .wr_idx   (sel.idx),
        .wr_data  (data_wdata),
        .wr_be_n  (data_be_n),
        .cmd_word (cmd_word),
        .win_word (win_word)
    );

    cfg_rd_mux #(
        .VENDOR_ID     (VENDOR_ID),
        .DEVICE_ID     (DEVICE_ID),
        .REVISION_ID   (REVISION_ID),
        .CLASS_CODE    (CLASS_CODE),
        .SUB_VENDOR_ID (SUB_VENDOR_ID),
        .SUB_ID        (SUB_ID),
        .STATUS_VALUE  (STATUS_VALUE)
    ) u_rdmux (
        .rd_en    (rd_en),
        .rd_idx   (sel.idx),
        .cmd_word (cmd_word),
        .win_word (win_word),
        .rd_data  (cfg_rdata)
    );

    // Drive the exported decode controls
    always_comb begin
        cfg_claim  = sel.active;
        mem_enable = cmd_word[1];
        bar0_base  = win_word[31:WIN_SIZE_LOG2];
    end
endmodule

// File: tb/pci_cfg_header_bench.sv
module pci_cfg_header_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic        addr_idsel = 1'b0;
    logic [3:0]  addr_cmd = 4'h0;
    logic [7:0]  addr_ad = 8'h0;
    logic        data_valid = 1'b0;
    logic [31:0] data_wdata = 32'h0;
    logic [3:0]  data_be_n = 4'hF;
    logic        cfg_claim;
    logic [31:0] cfg_rdata;
    logic        mem_enable;
    logic [6:0]  bar0_base;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    pci_cfg_header u_pci_cfg_header (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_idsel(addr_idsel),
        .addr_cmd(addr_cmd), .addr_ad(addr_ad), .data_valid(data_valid),
        .data_wdata(data_wdata), .data_be_n(data_be_n), .cfg_claim(cfg_claim),
        .cfg_rdata(cfg_rdata), .mem_enable(mem_enable), .bar0_base(bar0_base)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        idsel;
        logic [3:0]  cmd;
        logic [7:0]  ad;
        logic [31:0] wdata;
        logic [3:0]  be_n;
        logic        claim;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  1'b1, 4'hA, 8'h00, 32'h0,         4'h0, 1'b1, 32'h00014150}, // R2
        '{4'd3,  1'b1, 4'hA, 8'h04, 32'h0,         4'h0, 1'b1, 32'h02000002}, // R3
        '{4'd6,  1'b1, 4'hA, 8'h08, 32'h0,         4'h0, 1'b1, 32'h05800001}, // R6
        '{4'd6,  1'b1, 4'hA, 8'h2C, 32'h0,         4'h0, 1'b1, 32'h00014150}, // R6
        '{4'd1,  1'b0, 4'hA, 8'h00, 32'h0,         4'h0, 1'b0, 32'h0},        // R1 no select
        '{4'd1,  1'b1, 4'h6, 8'h00, 32'h0,         4'h0, 1'b0, 32'h0},        // R1 memory read
        '{4'd1,  1'b1, 4'hA, 8'h01, 32'h0,         4'h0, 1'b0, 32'h0},        // R1 type-1 bits
        '{4'd4,  1'b1, 4'hB, 8'h10, 32'h3000_0000, 4'h0, 1'b1, 32'h0},        // R4
        '{4'd4,  1'b1, 4'hA, 8'h10, 32'h0,         4'h0, 1'b1, 32'h3000_0000},// R4
        '{4'd7,  1'b1, 4'hB, 8'h10, 32'hFFFF_FFFF, 4'hF, 1'b1, 32'h0},        // R7 no lanes
        '{4'd7,  1'b1, 4'hA, 8'h10, 32'h0,         4'h0, 1'b1, 32'h3000_0000},// R7
        '{4'd5,  1'b1, 4'hB, 8'h10, 32'hFFFF_FFFF, 4'h0, 1'b1, 32'h0},        // R5
        '{4'd5,  1'b1, 4'hA, 8'h10, 32'h0,         4'h0, 1'b1, 32'hFE00_0000},// R5
        '{4'd7,  1'b1, 4'hB, 8'h10, 32'h1234_5678, 4'h7, 1'b1, 32'h0},        // R7 lane 3 only
        '{4'd7,  1'b1, 4'hA, 8'h10, 32'h0,         4'h0, 1'b1, 32'h1200_0000},// R7
        '{4'd5,  1'b1, 4'hB, 8'h10, 32'hAAAA_AAAA, 4'h8, 1'b1, 32'h0},        // R5 low lanes
        '{4'd5,  1'b1, 4'hA, 8'h10, 32'h0,         4'h0, 1'b1, 32'h1200_0000},// R5
        '{4'd9,  1'b1, 4'hB, 8'h0C, 32'hFFFF_FFFF, 4'h0, 1'b1, 32'h0},        // R9
        '{4'd9,  1'b1, 4'hA, 8'h0C, 32'h0,         4'h0, 1'b1, 32'h0},        // R9
        '{4'd10, 1'b1, 4'hB, 8'h00, 32'hFFFF_FFFF, 4'h0, 1'b1, 32'h0},        // R10
        '{4'd10, 1'b1, 4'hA, 8'h00, 32'h0,         4'h0, 1'b1, 32'h00014150}, // R10
        '{4'd7,  1'b1, 4'hB, 8'h04, 32'h0000_0000, 4'h1, 1'b1, 32'h0},        // R7 lane 0 off
        '{4'd7,  1'b1, 4'hA, 8'h04, 32'h0,         4'h0, 1'b1, 32'h02000002}, // R7
        '{4'd8,  1'b1, 4'hB, 8'h04, 32'hFFFF_FFFD, 4'h0, 1'b1, 32'h0},        // R8
        '{4'd8,  1'b1, 4'hA, 8'h04, 32'h0,         4'h0, 1'b1, 32'h02000000}, // R8
        '{4'd8,  1'b1, 4'hB, 8'h04, 32'hFFFF_FFFF, 4'h0, 1'b1, 32'h0},        // R8
        '{4'd8,  1'b1, 4'hA, 8'h04, 32'h0,         4'h0, 1'b1, 32'h02000002}, // R8
        '{4'd1,  1'b0, 4'hB, 8'h10, 32'h0,         4'h0, 1'b0, 32'h0},        // R1 unselected write
        '{4'd1,  1'b1, 4'hA, 8'h10, 32'h0,         4'h0, 1'b1, 32'h1200_0000},// R1
        '{4'd9,  1'b1, 4'hA, 8'h40, 32'h0,         4'h0, 1'b1, 32'h0}         // R9
    };

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One configuration access: address phase, optional idle gap, data phase
    task automatic access(input int req, input logic sel, input logic [3:0] cmd, input logic [7:0] ad,
                          input logic [31:0] wd, input logic [3:0] be, input logic exp_claim,
                          input logic [31:0] exp_rd, input int gap);
        @(negedge clk);
        addr_valid = 1'b1; addr_idsel = sel; addr_cmd = cmd; addr_ad = ad;
        @(negedge clk);
        addr_valid = 1'b0; addr_idsel = 1'b0;
        check(req, "claim", {31'b0, cfg_claim}, {31'b0, exp_claim});
        check(req, "rdata", cfg_rdata, exp_rd);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(11, "claim held", {31'b0, cfg_claim}, {31'b0, exp_claim}); // R11
            check(11, "rdata held", cfg_rdata, exp_rd);
        end
        data_valid = 1'b1; data_wdata = wd; data_be_n = be;
        @(negedge clk);
        data_valid = 1'b0; data_be_n = 4'hF;
        check(11, "claim released", {31'b0, cfg_claim}, 32'h0); // R11
        check(11, "rdata idle", cfg_rdata, 32'h0);
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state at the ports
        check(3, "reset claim", {31'b0, cfg_claim}, 32'h0);
        check(3, "reset mem_enable", {31'b0, mem_enable}, 32'h1);
        check(4, "reset bar0_base", {25'b0, bar0_base}, 32'h0);
        check(11, "reset rdata", cfg_rdata, 32'h0);

        for (int i = 0; i < NV; i++)
            access(int'(TBL[i].req), TBL[i].idsel, TBL[i].cmd, TBL[i].ad, TBL[i].wdata,
                   TBL[i].be_n, TBL[i].claim, TBL[i].rdata, 0);

        // R4 exported base after lane-3 write of 0x12
        check(4, "bar0_base", {25'b0, bar0_base}, 32'h09);
        // R8 memory enable port follows command bit 1
        access(8, 1'b1, 4'hB, 8'h04, 32'h0, 4'h0, 1'b1, 32'h0, 0);
        check(8, "mem_enable cleared", {31'b0, mem_enable}, 32'h0);
        access(8, 1'b1, 4'hB, 8'h04, 32'h2, 4'hE, 1'b1, 32'h0, 0);
        check(8, "mem_enable restored", {31'b0, mem_enable}, 32'h1);
        // R11 claim held across idle cycles before the data phase
        access(11, 1'b1, 4'hA, 8'h08, 32'h0, 4'h0, 1'b1, 32'h05800001, 3);
        // R3 reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(3, 1'b1, 4'hA, 8'h10, 32'h0, 4'h0, 1'b1, 32'h0, 0);
        access(3, 1'b1, 4'hA, 8'h04, 32'h0, 4'h0, 1'b1, 32'h02000002, 0);
        // R9 another unimplemented offset
        access(9, 1'b1, 4'hA, 8'h3C, 32'h0, 4'h0, 1'b1, 32'h0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule